// File: doc/BRIEF.md
# Event Performance Counter Unit

The unit holds a small bank of 32-bit event counters that software controls through a register interface. Software first writes a counter index into a select register. It then reaches the chosen counter's event code and count through two shared windows. Each counter follows one event source, chosen by its code. A source is either one strobe from a vector of internal event pulses, either of two external event lines, or the two external lines together.

Counting needs a global enable bit and the counter's own enable bit. When a count wraps past its maximum, the counter's overflow flag sets. A single active-low interrupt line reports every overflow whose interrupt is enabled.

Each request states whether the requester runs in user mode. If the user-enable bit is clear, a user-mode request is refused with a fault and changes nothing. Each request gets a response one cycle later.

Top module: `evt_perf_unit`

## Requirements
- R1: Four 32-bit counters exist. Register 0 (bits [1:0]) selects one of them. Register 1 (event code, bits [7:0]) and register 2 (count, bits [31:0]) act only on the selected counter. Register 7 reads 0 and ignores writes.
- R2: Event codes below NUM_INT_EVT (16 by default) count pulses on the internal strobe with that index. Code 0x70 counts pulses on external line 0, and code 0x71 counts pulses on external line 1.
- R3: Code 0x72 counts pulses on both external lines. The count rises by 2 in a cycle where both lines pulse.
- R4: Codes 0x60–0x6F and 0x73–0xFF never increment a counter. Codes from NUM_INT_EVT up to 0x5F never increment a counter either.
- R5: A counter increments only when the global enable (register 3, bit 8) and its own enable (register 3, bit i) are both 1.
- R6: A count write takes priority over an event in the same cycle. The written value is stored and that cycle's event is lost.
- R7: A counter that wraps past 0xFFFFFFFF sets its overflow flag (register 5, bit i). Writing 1 to a flag bit clears it. A wrap in the same cycle as the clear leaves the flag set.
- R8: irq_n is 0 exactly while some overflow flag is set together with its interrupt-enable bit (register 4, bit i).
- R9: A privileged request (req_user=0) always completes. One cycle later rsp_valid=1 and rsp_fault=0. A read returns the register value from before that edge, and a write returns 0.
- R10: When the user-enable bit (register 6, bit 0) is 0, any user-mode request gives rsp_fault=1 and rsp_rdata=0, and it changes no register or count.
- R11: When the user-enable bit is 1, user-mode requests behave like privileged ones. The one exception is a user write to register 6, which always faults and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_user | input | 1 | 1 = requester in user mode |
| req_addr | input | 3 | Register address |
| req_wdata | input | 32 | Write data |
| int_evt | input | NUM_INT_EVT | Internal event strobes |
| ext_evt | input | 2 | External event lines |
| rsp_valid | output | 1 | Response present |
| rsp_fault | output | 1 | Illegal-instruction fault for the request |
| rsp_rdata | output | 32 | Read data, 0 on fault or write |
| irq_n | output | 1 | Active-low overflow interrupt |

## Verification
The assertions check the following on every cycle:
- A reserved code or a disabled counter holds its count.
- A count write lands exactly.
- A wrap leaves a small count behind.
- A double external pulse under the combined code adds exactly two.
- A refused request returns no data and leaves the control registers untouched, and privileged requests never fault.

Only the bench scenarios show the behaviours that depend on history:
- the overflow flag and interrupt life cycle, including a wrap during a clear;
- reads returning state from before the edge;
- the user-enable transitions;
- the count values accumulated across thousands of mixed random events and accesses.

// File: rtl/evpc_pkg.sv
`timescale 1ns/1ps
package evpc_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned CNT_W  = DATA_W;
    localparam int unsigned CODE_W = 8;
    localparam int unsigned ADDR_W = 3;

    localparam logic [CODE_W-1:0] EV_EXT_A    = 8'h70;
    localparam logic [CODE_W-1:0] EV_EXT_B    = 8'h71;
    localparam logic [CODE_W-1:0] EV_EXT_PAIR = 8'h72;

    localparam int unsigned GEN_BIT = 8;

    typedef enum logic [ADDR_W-1:0] {
        RA_SEL  = 3'd0,
        RA_EVT  = 3'd1,
        RA_CNT  = 3'd2,
        RA_ENA  = 3'd3,
        RA_IEN  = 3'd4,
        RA_OVF  = 3'd5,
        RA_UEN  = 3'd6,
        RA_NONE = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/evpc_evt_decode.sv
`timescale 1ns/1ps
module evpc_evt_decode
    import evpc_pkg::*;
#(
    parameter int unsigned NUM_INT_EVT = 16
) (
    input  logic [CODE_W-1:0]      code,
    input  logic [NUM_INT_EVT-1:0] int_evt,
    input  logic [1:0]             ext_evt,
    output logic [1:0]             inc
);
    localparam int unsigned IDX_W = (NUM_INT_EVT > 1) ? $clog2(NUM_INT_EVT) : 1;

    always_comb begin
        inc = 2'd0;
        if ({{(32-CODE_W){1'b0}}, code} < 32'(NUM_INT_EVT)) begin
            inc = {1'b0, int_evt[code[IDX_W-1:0]]};
        end else begin
            case (code)
                EV_EXT_A:    inc = {1'b0, ext_evt[0]};
                EV_EXT_B:    inc = {1'b0, ext_evt[1]};
                EV_EXT_PAIR: inc = {1'b0, ext_evt[0]} + {1'b0, ext_evt[1]};
                default:     inc = 2'd0;
            endcase
        end
    end
endmodule

// File: rtl/evpc_counter.sv
`timescale 1ns/1ps
module evpc_counter
    import evpc_pkg::*;
#(
    parameter int unsigned NUM_INT_EVT = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CODE_W-1:0]      code,
    input  logic [NUM_INT_EVT-1:0] int_evt,
    input  logic [1:0]             ext_evt,
    input  logic                   cnt_en,
    input  logic                   wr_en,
    input  logic [CNT_W-1:0]       wr_data,
    output logic [CNT_W-1:0]       cnt_q,
    output logic                   wrap
);
    logic [1:0]       inc;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W:0]   sum;

    evpc_evt_decode #(.NUM_INT_EVT(NUM_INT_EVT)) u_dec (
        .code    (code),
        .int_evt (int_evt),
        .ext_evt (ext_evt),
        .inc     (inc)
    );

    always_comb begin
        sum = {1'b0, cnt_q} + (CNT_W+1)'(cnt_en ? inc : 2'd0);
        if (wr_en) begin
            cnt_d = wr_data;
            wrap  = 1'b0;
        end else begin
            cnt_d = sum[CNT_W-1:0];
            wrap  = sum[CNT_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    p_reserved_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && (code inside {[8'h60:8'h6F], [8'h73:8'hFF]})) |=> $stable(cnt_q));

    p_disabled_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !cnt_en) |=> $stable(cnt_q));

    p_write_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cnt_q == $past(wr_data)));

    p_wrap_small_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt_q < CNT_W'(2)));

    p_pair_adds_two_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !wr_en && code == EV_EXT_PAIR && ext_evt == 2'b11)
        |=> (cnt_q == $past(cnt_q) + CNT_W'(2)));
endmodule

// File: rtl/evt_perf_unit.sv
`timescale 1ns/1ps
module evt_perf_unit
    import evpc_pkg::*;
#(
    parameter int unsigned NUM_CNT     = 4,
    parameter int unsigned NUM_INT_EVT = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic                   req_user,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    input  logic [NUM_INT_EVT-1:0] int_evt,
    input  logic [1:0]             ext_evt,
    output logic                   rsp_valid,
    output logic                   rsp_fault,
    output logic [DATA_W-1:0]      rsp_rdata,
    output logic                   irq_n
);
    localparam int unsigned SEL_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;

    typedef struct packed {
        logic [SEL_W-1:0]               sel;
        logic [NUM_CNT-1:0][CODE_W-1:0] evt;
        logic [NUM_CNT-1:0]             ena;
        logic                           gen;
        logic [NUM_CNT-1:0]             ien;
        logic [NUM_CNT-1:0]             ovf;
        logic                           uen;
        logic                           rsp_valid;
        logic                           rsp_fault;
        logic [DATA_W-1:0]              rsp_rdata;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_val;
    logic [NUM_CNT-1:0]            cnt_wr;
    logic [NUM_CNT-1:0]            cnt_wrap;
    logic                          fault;
    logic                          acc_ok;
    logic                          wr_ok;
    logic [DATA_W-1:0]             rd_val;
    reg_addr_e                     addr;

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        evpc_counter #(.NUM_INT_EVT(NUM_INT_EVT)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .code    (st_q.evt[i]),
            .int_evt (int_evt),
            .ext_evt (ext_evt),
            .cnt_en  (st_q.gen & st_q.ena[i]),
            .wr_en   (cnt_wr[i]),
            .wr_data (req_wdata),
            .cnt_q   (cnt_val[i]),
            .wrap    (cnt_wrap[i])
        );
    end

    always_comb begin
        addr   = reg_addr_e'(req_addr);
        fault  = req_valid && req_user &&
                 (!st_q.uen || (req_write && addr == RA_UEN));
        acc_ok = req_valid && !fault;
        wr_ok  = acc_ok && req_write;

        rd_val = '0;
        case (addr)
            RA_SEL: rd_val[SEL_W-1:0]   = st_q.sel;
            RA_EVT: rd_val[CODE_W-1:0]  = st_q.evt[st_q.sel];
            RA_CNT: rd_val              = cnt_val[st_q.sel];
            RA_ENA: begin
                rd_val[NUM_CNT-1:0] = st_q.ena;
                rd_val[GEN_BIT]     = st_q.gen;
            end
            RA_IEN: rd_val[NUM_CNT-1:0] = st_q.ien;
            RA_OVF: rd_val[NUM_CNT-1:0] = st_q.ovf;
            RA_UEN: rd_val[0]           = st_q.uen;
            default: rd_val = '0;
        endcase

        for (int i = 0; i < NUM_CNT; i++) begin
            cnt_wr[i] = wr_ok && addr == RA_CNT && st_q.sel == SEL_W'(i);
        end

        st_d           = st_q;
        st_d.rsp_valid = req_valid;
        st_d.rsp_fault = fault;
        st_d.rsp_rdata = (acc_ok && !req_write) ? rd_val : '0;

        if (wr_ok) begin
            case (addr)
                RA_SEL: st_d.sel = req_wdata[SEL_W-1:0];
                RA_EVT: st_d.evt[st_q.sel] = req_wdata[CODE_W-1:0];
                RA_ENA: begin
                    st_d.ena = req_wdata[NUM_CNT-1:0];
                    st_d.gen = req_wdata[GEN_BIT];
                end
                RA_IEN: st_d.ien = req_wdata[NUM_CNT-1:0];
                RA_OVF: st_d.ovf = st_q.ovf & ~req_wdata[NUM_CNT-1:0];
                RA_UEN: st_d.uen = req_wdata[0];
                default: ;
            endcase
        end
        st_d.ovf = st_d.ovf | cnt_wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_fault = st_q.rsp_fault;
    assign rsp_rdata = st_q.rsp_rdata;
    assign irq_n     = ~|(st_q.ovf & st_q.ien);

    p_fault_no_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_rdata == '0));

    p_fault_no_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_user && !st_q.uen)
        |=> ($stable(st_q.sel) && $stable(st_q.evt) && $stable(st_q.ena) &&
             $stable(st_q.ien) && $stable(st_q.uen) && $stable(st_q.gen)));

    p_priv_completes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_user) |=> (rsp_valid && !rsp_fault));

    p_user_uen_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_user && req_addr == RA_UEN)
        |=> (rsp_fault && $stable(st_q.uen)));
endmodule

// File: tb/tb_evt_perf_unit.sv
`timescale 1ns/1ps
module tb_evt_perf_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
    logic [2:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [15:0] int_evt = '0;
    logic [1:0]  ext_evt = '0;
    logic        rsp_valid, rsp_fault, irq_n;
    logic [31:0] rsp_rdata;

    int n_chk = 0, n_bad = 0;

    bit [1:0]  m_sel;
    bit [7:0]  m_evt [4];
    bit [31:0] m_cnt [4];
    bit [3:0]  m_en, m_ien, m_ovf;
    bit        m_gen, m_uen;

    evt_perf_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_user(req_user), .req_addr(req_addr), .req_wdata(req_wdata),
        .int_evt(int_evt), .ext_evt(ext_evt), .rsp_valid(rsp_valid),
        .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata), .irq_n(irq_n)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit [1:0] f_inc(bit [7:0] code, bit [15:0] ie, bit [1:0] ee);
        if (code < 8'd16) return {1'b0, ie[code[3:0]]};
        if (code == 8'h70) return {1'b0, ee[0]};
        if (code == 8'h71) return {1'b0, ee[1]};
        if (code == 8'h72) return {1'b0, ee[0]} + {1'b0, ee[1]};
        return 2'd0;
    endfunction

    function automatic bit [31:0] f_read(bit [2:0] a);
        case (a)
            3'd0: return {30'd0, m_sel};
            3'd1: return {24'd0, m_evt[m_sel]};
            3'd2: return m_cnt[m_sel];
            3'd3: return {23'd0, m_gen, 4'd0, m_en};
            3'd4: return {28'd0, m_ien};
            3'd5: return {28'd0, m_ovf};
            3'd6: return {31'd0, m_uen};
            default: return 32'd0;
        endcase
    endfunction

    task automatic step(input bit v, input bit w, input bit u, input bit [2:0] a,
                        input bit [31:0] d, input bit [15:0] ie, input bit [1:0] ee,
                        input string tag);
        bit flt;
        bit [31:0] exp_rd;
        bit [3:0] wraps;
        string ftag;
        @(negedge clk);
        req_valid = v; req_write = w; req_user = u; req_addr = a;
        req_wdata = d; int_evt = ie; ext_evt = ee;
        flt  = v && u && (!m_uen || (w && a == 3'd6));
        ftag = !u ? "R9" : (!m_uen ? "R10" : "R11");
        exp_rd = (v && !flt && !w) ? f_read(a) : 32'd0;
        wraps = '0;
        for (int i = 0; i < 4; i++) begin
            bit [1:0] inc;
            bit [32:0] s;
            inc = (m_gen && m_en[i]) ? f_inc(m_evt[i], ie, ee) : 2'd0;
            if (v && w && !flt && a == 3'd2 && m_sel == 2'(i)) m_cnt[i] = d;
            else begin
                s = {1'b0, m_cnt[i]} + 33'(inc);
                m_cnt[i] = s[31:0];
                wraps[i] = s[32];
            end
        end
        if (v && w && !flt) begin
            case (a)
                3'd0: m_sel = d[1:0];
                3'd1: m_evt[m_sel] = d[7:0];
                3'd3: begin m_en = d[3:0]; m_gen = d[8]; end
                3'd4: m_ien = d[3:0];
                3'd5: m_ovf = m_ovf & ~d[3:0];
                3'd6: m_uen = d[0];
                default: ;
            endcase
        end
        m_ovf = m_ovf | wraps;
        @(posedge clk);
        #1;
        chk("R8 irq_n", {31'd0, irq_n}, {31'd0, ~|(m_ovf & m_ien)});
        if (v) begin
            chk({ftag, " fault"}, {31'd0, rsp_fault}, {31'd0, flt});
            chk({tag, " rdata"}, rsp_rdata, exp_rd);
        end
    endtask

    task automatic wr(input bit [2:0] a, input bit [31:0] d, input string tag);
        step(1, 1, 0, a, d, '0, '0, tag);
    endtask

    task automatic rd(input bit [2:0] a, input string tag);
        step(1, 0, 0, a, '0, '0, '0, tag);
    endtask

    function automatic bit [7:0] pick_code();
        case ($urandom_range(0, 5))
            0, 1: return 8'($urandom_range(0, 15));
            2: return 8'h70;
            3: return 8'h71;
            4: return 8'h72;
            default: return ($urandom_range(0, 1) != 0) ? 8'($urandom_range(8'h60, 8'h6F))
                                                         : 8'($urandom_range(8'h73, 8'hFF));
        endcase
    endfunction

    initial begin
        #(20 * 150000);
        n_chk++; n_bad++;
        $display("FAIL R9 watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(posedge clk);
        #1;
        chk("R9 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R8 reset irq_n", {31'd0, irq_n}, 32'd1);
        rst_n = 1'b1;
        rd(3'd0, "R1 reset sel");
        rd(3'd2, "R1 reset count");
        rd(3'd5, "R7 reset ovf");
        rd(3'd7, "R1 unused reg");

        // counter 1 on combined externals, near wrap
        wr(3'd0, 32'd1, "R1");
        wr(3'd1, 32'h72, "R3");
        wr(3'd2, 32'hFFFF_FFFE, "R1");
        wr(3'd3, 32'h102, "R5");
        wr(3'd4, 32'h2, "R8");
        step(0, 0, 0, 3'd0, '0, '0, 2'b11, "R3");
        rd(3'd2, "R3 pair wrap count");
        rd(3'd5, "R7 flag set");
        wr(3'd5, 32'h2, "R7 clear");
        rd(3'd5, "R7 flag cleared");
        // clear while wrapping: flag stays
        wr(3'd2, 32'hFFFF_FFFF, "R7");
        step(1, 1, 0, 3'd5, 32'hF, '0, 2'b01, "R7 clear during wrap");
        rd(3'd5, "R7 wrap beats clear");
        wr(3'd5, 32'hF, "R7");

        // write beats event
        step(1, 1, 0, 3'd2, 32'h55, '0, 2'b11, "R6");
        rd(3'd2, "R6 write wins");

        // reserved codes
        wr(3'd1, 32'h65, "R4");
        repeat (3) step(0, 0, 0, 3'd0, '0, 16'hFFFF, 2'b11, "R4");
        rd(3'd2, "R4 reserved 0x65 holds");
        wr(3'd1, 32'h20, "R4");
        repeat (3) step(0, 0, 0, 3'd0, '0, 16'hFFFF, 2'b11, "R4");
        rd(3'd2, "R4 code 0x20 holds");

        // enables
        wr(3'd1, 32'h70, "R2");
        wr(3'd3, 32'h002, "R5");
        step(0, 0, 0, 3'd0, '0, '0, 2'b01, "R5");
        rd(3'd2, "R5 global off holds");
        wr(3'd3, 32'h100, "R5");
        step(0, 0, 0, 3'd0, '0, '0, 2'b01, "R5");
        rd(3'd2, "R5 local off holds");
        wr(3'd3, 32'h102, "R5");
        step(0, 0, 0, 3'd0, '0, '0, 2'b01, "R2");
        step(0, 0, 0, 3'd0, '0, '0, 2'b10, "R2");
        rd(3'd2, "R2 ext0 only");
        wr(3'd1, 32'h05, "R2");
        repeat (3) step(0, 0, 0, 3'd0, '0, 16'h0020, 2'b00, "R2");
        step(0, 0, 0, 3'd0, '0, 16'hFFDF, 2'b11, "R2");
        rd(3'd2, "R2 internal strobe 5");

        // user access
        step(1, 0, 1, 3'd2, '0, '0, '0, "R10 user read");
        step(1, 1, 1, 3'd2, 32'h1234, '0, '0, "R10 user write");
        step(1, 1, 1, 3'd0, 32'h3, '0, '0, "R10 user sel write");
        rd(3'd2, "R10 count unchanged");
        rd(3'd0, "R10 sel unchanged");
        wr(3'd6, 32'h1, "R11");
        step(1, 0, 1, 3'd2, '0, '0, '0, "R11 user read");
        step(1, 1, 1, 3'd6, 32'h0, '0, '0, "R11 user uen write");
        step(1, 1, 1, 3'd2, 32'hABCD, '0, '0, "R11 user write");
        rd(3'd2, "R11 count written");
        rd(3'd6, "R11 uen still set");

        // random phase
        for (int k = 0; k < 3000; k++) begin
            bit [2:0]  a;
            bit [31:0] d;
            bit        w;
            string     t;
            a = 3'($urandom_range(0, 7));
            w = ($urandom_range(0, 2) == 0);
            d = $urandom;
            if (a == 3'd2 && $urandom_range(0, 1) != 0) d = 32'hFFFF_FFFF - 32'($urandom_range(0, 6));
            if (a == 3'd1) d = {24'd0, pick_code()};
            if (a == 3'd3 && $urandom_range(0, 3) != 0) d[8] = 1'b1;
            if (a == 3'd6 && $urandom_range(0, 3) == 0) d[0] = 1'b0;
            case (a)
                3'd3: t = "R5";
                3'd4: t = "R8";
                3'd5: t = "R7";
                3'd6: t = "R11";
                default: t = "R1";
            endcase
            step($urandom_range(0, 3) != 0, w, $urandom_range(0, 2) == 0, a, d,
                 16'($urandom), 2'($urandom), {t, " random"});
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule